// File: doc/BRIEF.md
# Two-Level Microcode and Nanocode Control Sequencer

This block is the control engine of a small datapath that runs complex, multi-cycle instructions. The block takes a 16-bit opcode word through a valid/ready handshake. It does not drive the datapath from the opcode directly. The top four opcode bits select the entry point of a microcode routine. Each microcode step names one shared nanocode routine, and each nanocode word drives one cycle of datapath strobes. These strobes cover the ALU function, address calculation, the register write and the bus request.

Some instructions carry offsets or absolute addresses. Their microcode calls a nanocode routine that asks for an extension word on the same input handshake. The sequence waits until that word arrives. The last nanocode word of the last microcode step finishes the instruction. The block then pulses `done` and accepts the next opcode.

Opcode classes that have no routine are sent to a trap routine. The trap routine raises an error flag.

Top module: `ucodeSequencer`

## Requirements
- R1: While reset is held, and just after it, `instrReady` is 1. `done`, `ctrlValid`, `ctrlWord`, `errFlag` and `extWord` are all 0.
- R2: An opcode is taken at a clock edge where `instrValid` and `instrReady` are both high and no instruction is running. From the next cycle, `srcEa` equals opcode bits [5:0] and `dstEa` equals opcode bits [11:6]. Both hold until the next opcode is taken. `instrReady` is low while the instruction runs, except during an extension-word request.
- R3: The control word uses these bit positions. Bits [2:0] are the ALU function (0 idle, 1 pass, 2 add). Bit 3 enables the address calculation. Bit 4 is the bus request. Bit 5 is the register write. Bit 6 loads an extension word. Bit 7 signals a trap.
- R4: Class 1 (opcode bits [15:12] = 1) is a register move. It emits the words 0x11 and then 0x30 in consecutive cycles.
- R5: Class 2 is an add with an offset. It emits 0x40, 0x0A, 0x08, 0x11, 0x02 and 0x30. It reuses the shared routines for reading, writing and fetching an extension word.
- R6: Class 3 is a move from an absolute address. It fetches two extension words and emits 0x40, 0x40, 0x0A, 0x08, 0x11 and 0x30.
- R7: During a 0x40 step, `instrReady` is high and the sequence stalls while `instrValid` is low. During a stall, `ctrlValid` is 0 and no word is emitted. When `instrValid` rises, the word is emitted and `extWord` takes `instrData` in the next cycle.
- R8: `done` is high for exactly one cycle, the cycle right after the last control word. `instrReady` is high in that cycle and `ctrlValid` is low.
- R9: Any class other than 1, 2 or 3 emits only the trap word 0x80. `errFlag` is 1 when `done` pulses. It stays 1 until the next opcode is taken, which clears it.
- R10: `ctrlWord` is 0 in every cycle where `ctrlValid` is 0.
- R11: An opcode presented in the cycle where `done` is high is taken at once, with no idle cycle between instructions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| instrValid | input | 1 | An opcode or extension word is on `instrData` |
| instrData | input | 16 | Opcode or extension word |
| instrReady | output | 1 | The sequencer accepts `instrData` this cycle |
| ctrlValid | output | 1 | `ctrlWord` is being executed this cycle |
| ctrlWord | output | 8 | Datapath strobes (layout in R3) |
| done | output | 1 | One-cycle pulse at the end of an instruction |
| srcEa | output | 6 | Source effective-address field of the current opcode |
| dstEa | output | 6 | Destination effective-address field of the current opcode |
| extWord | output | 16 | Most recently accepted extension word |
| errFlag | output | 1 | The current instruction had an unmapped class |

## Verification
Each opcode class is run and its full stream of control words is compared in order. The register move and the two extended instructions show whether the shared nanocode routines are reached from the right microcode steps. The absolute move shows whether two back-to-back extension fetches are kept apart.

The same offset instruction is run once with its extension word supplied at once and once after a delay of several cycles. This separates correct stalling from early or skipped steps. Unmapped classes at both ends of the code space show the trap path. A following legal opcode shows that the error flag clears.

Instructions chained in the `done` cycle show that no idle cycle is inserted between them.

// File: rtl/seqPkg.sv
package seqPkg;
  localparam int UPC_W = 4;
  localparam int NPC_W = 3;
  localparam int CW_W  = 8;

  typedef struct packed {
    logic       errSig;
    logic       extLoad;
    logic       regWe;
    logic       busReq;
    logic       addrEn;
    logic [2:0] aluOp;
  } ctrl_t;

  typedef struct packed {
    logic  last;
    logic  extReq;
    ctrl_t ctrl;
  } nanoWord_t;

  typedef struct packed {
    logic             last;
    logic [NPC_W-1:0] nanoAddr;
  } microWord_t;

  typedef struct packed {
    logic loadOp;
    logic stepNano;
    logic stepMicro;
    logic loadExt;
    logic setErr;
  } strobe_t;

  typedef struct packed {
    logic nanoLast;
    logic microLast;
    logic extReq;
    logic errSig;
  } status_t;

  localparam logic [2:0] ALU_IDLE = 3'd0;
  localparam logic [2:0] ALU_PASS = 3'd1;
  localparam logic [2:0] ALU_ADD  = 3'd2;

  // shared nanocode routine entry points
  localparam logic [NPC_W-1:0] N_READ  = NPC_W'(0);
  localparam logic [NPC_W-1:0] N_FETCH = NPC_W'(1);
  localparam logic [NPC_W-1:0] N_ADDR  = NPC_W'(2);
  localparam logic [NPC_W-1:0] N_ALU   = NPC_W'(4);
  localparam logic [NPC_W-1:0] N_WRITE = NPC_W'(5);
  localparam logic [NPC_W-1:0] N_TRAP  = NPC_W'(6);

  localparam logic [UPC_W-1:0] U_MOVE  = UPC_W'(0);
  localparam logic [UPC_W-1:0] U_ADDO  = UPC_W'(2);
  localparam logic [UPC_W-1:0] U_ABS   = UPC_W'(7);
  localparam logic [UPC_W-1:0] U_TRAP  = UPC_W'(12);

  function automatic nanoWord_t nanoRom(input logic [NPC_W-1:0] a);
    nanoWord_t w;
    w = '0;
    case (int'(a))
      0: begin w.ctrl.busReq = 1'b1; w.ctrl.aluOp = ALU_PASS; w.last = 1'b1; end
      1: begin w.ctrl.extLoad = 1'b1; w.extReq = 1'b1; w.last = 1'b1; end
      2: begin w.ctrl.addrEn = 1'b1; w.ctrl.aluOp = ALU_ADD; end
      3: begin w.ctrl.addrEn = 1'b1; w.last = 1'b1; end
      4: begin w.ctrl.aluOp = ALU_ADD; w.last = 1'b1; end
      5: begin w.ctrl.regWe = 1'b1; w.ctrl.busReq = 1'b1; w.last = 1'b1; end
      default: begin w.ctrl.errSig = 1'b1; w.last = 1'b1; end
    endcase
    return w;
  endfunction

  function automatic microWord_t mw(input logic [NPC_W-1:0] n, input logic l);
    microWord_t w;
    w.nanoAddr = n;
    w.last     = l;
    return w;
  endfunction

  function automatic microWord_t microRom(input logic [UPC_W-1:0] a);
    case (int'(a))
      0:  return mw(N_READ,  1'b0);
      1:  return mw(N_WRITE, 1'b1);
      2:  return mw(N_FETCH, 1'b0);
      3:  return mw(N_ADDR,  1'b0);
      4:  return mw(N_READ,  1'b0);
      5:  return mw(N_ALU,   1'b0);
      6:  return mw(N_WRITE, 1'b1);
      7:  return mw(N_FETCH, 1'b0);
      8:  return mw(N_FETCH, 1'b0);
      9:  return mw(N_ADDR,  1'b0);
      10: return mw(N_READ,  1'b0);
      11: return mw(N_WRITE, 1'b1);
      default: return mw(N_TRAP, 1'b1);
    endcase
  endfunction

  function automatic logic [UPC_W-1:0] microEntry(input logic [3:0] opClass);
    case (opClass)
      4'h1:    return U_MOVE;
      4'h2:    return U_ADDO;
      4'h3:    return U_ABS;
      default: return U_TRAP;
    endcase
  endfunction
endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import seqPkg::*;
#(
  parameter int DATA_W = 16,
  localparam int EA_W = (DATA_W - 4) / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] instrData,
  input  strobe_t           strb,
  output status_t           stat,
  output ctrl_t             ctrl,
  output logic [EA_W-1:0]   srcEa,
  output logic [EA_W-1:0]   dstEa,
  output logic [DATA_W-1:0] extWord,
  output logic              errFlag
);
  logic [UPC_W-1:0] microPc;
  logic [NPC_W-1:0] nanoPc;
  logic [UPC_W-1:0] entryPc;
  microWord_t entryMicro, curMicro, nextMicro;
  nanoWord_t  curNano;

  always_comb begin
    entryPc    = microEntry(instrData[DATA_W-1 -: 4]);
    entryMicro = microRom(entryPc);
    curMicro   = microRom(microPc);
    nextMicro  = microRom(microPc + UPC_W'(1));
    curNano    = nanoRom(nanoPc);
    stat.nanoLast  = curNano.last;
    stat.microLast = curMicro.last;
    stat.extReq    = curNano.extReq;
    stat.errSig    = curNano.ctrl.errSig;
    ctrl = curNano.ctrl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      microPc <= '0;
      nanoPc  <= '0;
      srcEa   <= '0;
      dstEa   <= '0;
      extWord <= '0;
      errFlag <= 1'b0;
    end else begin
      if (strb.loadOp) begin
        microPc <= entryPc;
        nanoPc  <= entryMicro.nanoAddr;
        srcEa   <= instrData[EA_W-1:0];
        dstEa   <= instrData[2*EA_W-1:EA_W];
        errFlag <= 1'b0;
      end else if (strb.stepMicro) begin
        microPc <= microPc + UPC_W'(1);
        nanoPc  <= nextMicro.nanoAddr;
      end else if (strb.stepNano) begin
        nanoPc  <= nanoPc + NPC_W'(1);
      end
      if (strb.loadExt) extWord <= instrData;
      if (strb.setErr)  errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/seqControl.sv
module seqControl
  import seqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    instrValid,
  input  status_t stat,
  output logic    instrReady,
  output logic    ctrlValid,
  output logic    done,
  output strobe_t strb
);
  typedef enum logic {S_IDLE, S_RUN} state_t;
  state_t state;
  logic stepOk, finish;

  always_comb begin
    stepOk     = (state == S_RUN) && (!stat.extReq || instrValid);
    finish     = stepOk && stat.nanoLast && stat.microLast;
    instrReady = (state == S_IDLE) || stat.extReq;
    ctrlValid  = stepOk;
    strb.loadOp    = (state == S_IDLE) && instrValid;
    strb.stepNano  = stepOk && !stat.nanoLast;
    strb.stepMicro = stepOk && stat.nanoLast && !stat.microLast;
    strb.loadExt   = stepOk && stat.extReq;
    strb.setErr    = stepOk && stat.errSig;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      done <= finish;
      if (strb.loadOp)  state <= S_RUN;
      else if (finish)  state <= S_IDLE;
    end
  end
endmodule

// File: rtl/ucodeSequencer.sv
module ucodeSequencer
  import seqPkg::*;
#(
  parameter int DATA_W = 16,
  localparam int EA_W = (DATA_W - 4) / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [DATA_W-1:0] instrData,
  output logic              instrReady,
  output logic              ctrlValid,
  output logic [CW_W-1:0]   ctrlWord,
  output logic              done,
  output logic [EA_W-1:0]   srcEa,
  output logic [EA_W-1:0]   dstEa,
  output logic [DATA_W-1:0] extWord,
  output logic              errFlag
);
  strobe_t strb;
  status_t stat;
  ctrl_t   ctrl;

  seqControl uCtl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .stat(stat),
    .instrReady(instrReady), .ctrlValid(ctrlValid), .done(done), .strb(strb)
  );

  seqDatapath #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .instrData(instrData), .strb(strb), .stat(stat),
    .ctrl(ctrl), .srcEa(srcEa), .dstEa(dstEa), .extWord(extWord), .errFlag(errFlag)
  );

  assign ctrlWord = ctrlValid ? CW_W'(ctrl) : '0;
endmodule

// File: rtl/ucodeSequencerChecker.sv
module ucodeSequencerChecker #(
  parameter int DATA_W = 16,
  localparam int EA_W = (DATA_W - 4) / 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrValid,
  input logic [DATA_W-1:0] instrData,
  input logic              instrReady,
  input logic              ctrlValid,
  input logic [7:0]        ctrlWord,
  input logic              done,
  input logic [EA_W-1:0]   srcEa,
  input logic [EA_W-1:0]   dstEa,
  input logic [DATA_W-1:0] extWord,
  input logic              errFlag
);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (instrReady && !ctrlValid));
  p_ext_handshake_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && ctrlWord[6]) |-> (instrValid && instrReady));
  p_ext_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && ctrlWord[6]) |=> (extWord == $past(instrData)));
  p_trap_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlValid && ctrlWord[7]) |=> errFlag);
  p_ea_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !instrReady |=> ($stable(srcEa) && $stable(dstEa)));
endmodule

bind ucodeSequencer ucodeSequencerChecker #(.DATA_W(DATA_W)) chk (.*);

// File: tb/ucodeSequencer_test.sv
module ucodeSequencer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrData = '0;
  logic        instrReady, ctrlValid, done, errFlag;
  logic [7:0]  ctrlWord;
  logic [5:0]  srcEa, dstEa;
  logic [15:0] extWord;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  ucodeSequencer uut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrData(instrData),
    .instrReady(instrReady), .ctrlValid(ctrlValid), .ctrlWord(ctrlWord),
    .done(done), .srcEa(srcEa), .dstEa(dstEa), .extWord(extWord), .errFlag(errFlag)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Runs one instruction; expWords holds the expected words, first in the low byte.
  task automatic execute(input string req, input logic [15:0] op, input int nExp,
                         input logic [63:0] expWords, input logic [15:0] ext0,
                         input logic [15:0] ext1, input int stall,
                         input bit expErr, input bit chained);
    logic [15:0] exts [2];
    int nSeen = 0;
    int extIdx = 0;
    int stallCnt = 0;
    int guard = 0;
    int cyc = 0;
    int lastCyc = -10;
    bit finished = 0;
    bit pendingExt = 0;
    exts[0] = ext0;
    exts[1] = ext1;
    if (chained) check("R11", "done high when next opcode offered", 32'(done), 32'd1);
    check("R2", "ready before accept", 32'(instrReady), 32'd1);
    instrData = op;
    instrValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
    check("R2", "srcEa", 32'(srcEa), 32'(op[5:0]));
    check("R2", "dstEa", 32'(dstEa), 32'(op[11:6]));
    check("R2", "ready while running", 32'(instrReady), 32'(expWords[7:0] == 8'h40));
    while (!finished && guard < 60) begin
      guard++;
      if (pendingExt) begin
        check("R7", "extWord captured", 32'(extWord), 32'(exts[extIdx]));
        extIdx++;
        stallCnt = 0;
        pendingExt = 0;
      end
      instrValid = 1'b0;
      if (instrReady && !done) begin
        if (stallCnt < stall) stallCnt++;
        else begin
          instrValid = 1'b1;
          instrData = exts[extIdx];
        end
      end
      #1;
      if (done) finished = 1;
      else begin
        if (ctrlValid) begin
          if (nSeen < nExp)
            check(req, $sformatf("R3 word %0d", nSeen), 32'(ctrlWord), 32'(expWords[8*nSeen +: 8]));
          else check(req, "extra control word", 32'(ctrlWord), 32'd0);
          nSeen++;
          lastCyc = cyc;
          if (ctrlWord[6]) pendingExt = 1;
        end else begin
          check("R10", "word zero when not valid", 32'(ctrlWord), 32'd0);
          if (instrReady) check("R7", "stalled step emits nothing", 32'(ctrlValid), 32'd0);
        end
        @(posedge clk);
        @(negedge clk);
        cyc++;
      end
    end
    instrValid = 1'b0;
    check("R8", "done reached", 32'(finished), 32'd1);
    check(req, "word count", 32'(nSeen), 32'(nExp));
    check("R8", "done right after last word", 32'(cyc), 32'(lastCyc + 1));
    check("R8", "ready with done", 32'(instrReady), 32'd1);
    check("R9", "error flag at done", 32'(errFlag), 32'(expErr));
  endtask

  task automatic testReset();
    #1;
    check("R1", "ready in reset", 32'(instrReady), 32'd1);
    check("R1", "done in reset", 32'(done), 32'd0);
    check("R1", "valid in reset", 32'(ctrlValid), 32'd0);
    check("R1", "word in reset", 32'(ctrlWord), 32'd0);
    check("R1", "errFlag in reset", 32'(errFlag), 32'd0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R1", "ready after reset", 32'(instrReady), 32'd1);
    check("R1", "extWord after reset", 32'(extWord), 32'd0);
    check("R1", "done after reset", 32'(done), 32'd0);
  endtask

  task automatic testMove();
    execute("R4", 16'h1A4B, 2, 64'h3011, 16'h0, 16'h0, 0, 1'b0, 1'b0);
    @(negedge clk);
    #1;
    check("R8", "done lasts one cycle", 32'(done), 32'd0);
  endtask

  task automatic testAddOffset();
    execute("R5", 16'h2123, 6, 64'h0000_3002_1108_0A40, 16'h1234, 16'h0, 0, 1'b0, 1'b0);
    @(negedge clk);
    execute("R7", 16'h2FC1, 6, 64'h0000_3002_1108_0A40, 16'hBEEF, 16'h0, 3, 1'b0, 1'b0);
    check("R7", "last extension kept", 32'(extWord), 32'hBEEF);
  endtask

  task automatic testAbsolute();
    @(negedge clk);
    execute("R6", 16'h3E07, 6, 64'h0000_3011_080A_4040, 16'hCAFE, 16'h0F0F, 2, 1'b0, 1'b0);
    check("R6", "second extension kept", 32'(extWord), 32'h0F0F);
  endtask

  task automatic testIllegal();
    @(negedge clk);
    execute("R9", 16'h0000, 1, 64'h80, 16'h0, 16'h0, 0, 1'b1, 1'b0);
    execute("R9", 16'hF123, 1, 64'h80, 16'h0, 16'h0, 0, 1'b1, 1'b1);
    execute("R9", 16'h1001, 2, 64'h3011, 16'h0, 16'h0, 0, 1'b0, 1'b1);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    execute("R11", 16'h1FFF, 2, 64'h3011, 16'h0, 16'h0, 0, 1'b0, 1'b0);
    execute("R11", 16'h2040, 6, 64'h0000_3002_1108_0A40, 16'h5A5A, 16'h0, 1, 1'b0, 1'b1);
    execute("R11", 16'h3001, 6, 64'h0000_3011_080A_4040, 16'h0001, 16'h8000, 0, 1'b0, 1'b1);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    testReset();
    testMove();
    testAddOffset();
    testAbsolute();
    testIllegal();
    testBackToBack();
    summary();
  end
endmodule